// File: doc/BRIEF.md
# Pooled Error-Class Dispatch Arbiter

This block sits between eight per-channel syndrome stages and a shared pool of later decoding units in a multi-channel block-code decoder. Each channel presents a finished block with a flag that says whether any syndrome was non-zero. Error-free blocks are accepted and retired in the cycle they arrive. Blocks with errors compete for an error-locator unit. When a locator reports its error count, a second arbiter routes the block to a solver. A count of one goes to a cheap single-root solver. A larger count goes to a full root-search unit. The pool can therefore be smaller than the channel count.

The channel side is a valid/ready stream. A channel raises `blk_valid` with `blk_nz` and must keep both stable until it sees `blk_ready` high in the same cycle. A low `blk_ready` is back-pressure: no locator is free, or another channel won the grant, so the channel waits. The unit side uses plain control pins. A start pulse is one cycle wide and carries the channel and locator index on shared buses. A unit is then taken as busy until it returns a one-cycle done pulse. The arithmetic inside the units is outside this block.

Top module: `pool_dispatch`

## Requirements
- R1: A channel with `blk_valid` high and `blk_nz` low sees `blk_ready` high in the same cycle, whatever the state of the pool. It starts no locator.
- R2: A granted channel gets the lowest-numbered free locator. In the same cycle `loc_start` is one-hot on that unit, `loc_chan` carries the channel number, and that channel's `blk_unit` field carries the locator index.
- R3: At most one error-carrying channel is granted per cycle. The winner is the first requester found scanning upward, with wrap, from a rotating pointer. The pointer is 0 after reset and moves to the winner's number plus one.
- R4: A locator that has been started is not started again until it has reported done and its result has left it. The earliest new grant comes in the cycle after the result leaves.
- R5: While no locator is free, `blk_ready` stays low for every error-carrying request. `blk_ready` is never high without `blk_valid`.
- R6: Take a locator that reported an error count of exactly 1. In the cycle after its done pulse, or later, it is dispatched to the lowest free single-root solver through `red_start`, with `sol_chan` and `sol_loc` identifying the channel and the locator.
- R7: If a count-1 result finds every single-root solver busy, it is dispatched to a free full root-search unit through `chn_start`.
- R8: A result with a count of 2 or more is dispatched only to a full root-search unit. It waits in its locator while all such units are busy, even when a single-root solver is free.
- R9: A result with a count of 0 frees its locator without starting any solver.
- R10: A solver is busy from its start until its done pulse and is not started while busy. A done pulse on an idle unit of any kind has no effect.
- R11: At most one solver start occurs per cycle. Locators holding results are served by rotating priority that starts at locator 0 after reset.
- R12: After reset every unit is free, and no start or ready is driven while no channel is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | NCH | Per-channel block offered |
| blk_nz | input | NCH | Per-channel flag: some syndrome non-zero |
| blk_ready | output | NCH | Per-channel acceptance (retired or granted) |
| blk_unit | output | NCH*LOC_W | Per-channel index of the granted locator |
| loc_start | output | NLOC | One-cycle start pulse per locator |
| loc_chan | output | CH_W | Channel being started on a locator |
| loc_done | input | NLOC | One-cycle done pulse per locator |
| loc_errcnt | input | NLOC*CNT_W | Error count per locator, valid with its done |
| red_start | output | NRED | Start pulse per single-root solver |
| red_done | input | NRED | Done pulse per single-root solver |
| chn_start | output | NCHN | Start pulse per full root-search unit |
| chn_done | input | NCHN | Done pulse per full root-search unit |
| sol_chan | output | CH_W | Channel of the block being dispatched to a solver |
| sol_loc | output | LOC_W | Locator holding the block being dispatched |

## Verification
Every cycle, the assertions check that error-free blocks are accepted at once and that `blk_ready` never appears without a request. They also check that at most one channel and at most one solver is started per cycle, that no locator is restarted in the cycle after its start, and that no solver is started while its own start/done history marks it busy. Other behaviours depend on a sequence of earlier events, and only the bench scenarios can show them. These are the rotating-pointer order across a sweep of every request pattern, a stall lifting once a locator's result leaves, the fallback of a single-error result to a full unit, a multi-error result waiting while a single-root solver sits free, a zero-count release, and a stray done pulse having no effect.

// File: rtl/pool_pkg.sv
package pool_pkg;

  typedef enum logic [1:0] {
    LOC_IDLE = 2'd0,
    LOC_RUN  = 2'd1,
    LOC_HOLD = 2'd2
  } loc_state_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pool_rr_pick.sv
module pool_rr_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic [N-1:0] gnt,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        idx    = W'(j);
      end
    end
  end
endmodule

// File: rtl/pool_first_free.sv
module pool_first_free #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] free,
  output logic [N-1:0] pick,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    pick = '0;
    idx  = '0;
    any  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && free[k]) begin
        any     = 1'b1;
        pick[k] = 1'b1;
        idx     = W'(k);
      end
    end
  end
endmodule

// File: rtl/pool_busy_map.sv
module pool_busy_map #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] start,
  input  logic [N-1:0] done,
  output logic [N-1:0] busy
);
  // a done on an idle unit clears nothing; a start only reaches idle units
  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy & ~done) | start;
  end
endmodule

// File: rtl/pool_dispatch.sv
module pool_dispatch
  import pool_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NLOC  = 3,
  parameter int NRED  = 2,
  parameter int NCHN  = 1,
  parameter int CNT_W = 4,
  localparam int CH_W  = idx_w(NCH),
  localparam int LOC_W = idx_w(NLOC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         blk_valid,
  input  logic [NCH-1:0]         blk_nz,
  output logic [NCH-1:0]         blk_ready,
  output logic [NCH*LOC_W-1:0]   blk_unit,
  output logic [NLOC-1:0]        loc_start,
  output logic [CH_W-1:0]        loc_chan,
  input  logic [NLOC-1:0]        loc_done,
  input  logic [NLOC*CNT_W-1:0]  loc_errcnt,
  output logic [NRED-1:0]        red_start,
  input  logic [NRED-1:0]        red_done,
  output logic [NCHN-1:0]        chn_start,
  input  logic [NCHN-1:0]        chn_done,
  output logic [CH_W-1:0]        sol_chan,
  output logic [LOC_W-1:0]       sol_loc
);
  localparam int RED_W = idx_w(NRED);
  localparam int CHN_W = idx_w(NCHN);

  // ---------------- locator bookkeeping ----------------
  loc_state_e           loc_st_q  [NLOC];
  logic [CH_W-1:0]      loc_ch_q  [NLOC];
  logic [CNT_W-1:0]     loc_cnt_q [NLOC];
  logic [NLOC-1:0]      loc_free;
  logic [NLOC-1:0]      loc_hold;
  logic [NLOC-1:0]      loc_rel;

  always_comb begin
    for (int l = 0; l < NLOC; l++) begin
      loc_free[l] = (loc_st_q[l] == LOC_IDLE);
      loc_hold[l] = (loc_st_q[l] == LOC_HOLD);
    end
  end

  // ---------------- stage 1: channel to locator ----------------
  logic [CH_W-1:0]  ptr1_q;
  logic [NCH-1:0]   req1, gnt1, gnt1_eff;
  logic [CH_W-1:0]  idx1;
  logic             any1;
  logic [NLOC-1:0]  lf_pick;
  logic [LOC_W-1:0] lf_idx;
  logic             lf_any;
  logic             grant1;

  assign req1 = blk_valid & blk_nz;

  pool_rr_pick #(.N(NCH), .W(CH_W)) u_pick_ch (
    .req(req1), .ptr(ptr1_q), .gnt(gnt1), .idx(idx1), .any(any1)
  );

  pool_first_free #(.N(NLOC), .W(LOC_W)) u_free_loc (
    .free(loc_free), .pick(lf_pick), .idx(lf_idx), .any(lf_any)
  );

  assign grant1    = any1 & lf_any;
  assign gnt1_eff  = grant1 ? gnt1 : '0;
  assign blk_ready = (blk_valid & ~blk_nz) | gnt1_eff;
  assign loc_start = grant1 ? lf_pick : '0;
  assign loc_chan  = idx1;

  for (genvar c = 0; c < NCH; c++) begin : g_unit
    assign blk_unit[c*LOC_W +: LOC_W] = gnt1_eff[c] ? lf_idx : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr1_q <= '0;
    else if (grant1)  ptr1_q <= (idx1 == CH_W'(NCH-1)) ? '0 : idx1 + 1'b1;
  end

  // ---------------- solver pools ----------------
  logic [NRED-1:0]  red_busy, rf_pick;
  logic [RED_W-1:0] rf_idx;
  logic             rf_any;
  logic [NCHN-1:0]  chn_busy, cf_pick;
  logic [CHN_W-1:0] cf_idx;
  logic             cf_any;

  pool_busy_map #(.N(NRED)) u_busy_red (
    .clk(clk), .rst_n(rst_n), .start(red_start), .done(red_done), .busy(red_busy)
  );
  pool_busy_map #(.N(NCHN)) u_busy_chn (
    .clk(clk), .rst_n(rst_n), .start(chn_start), .done(chn_done), .busy(chn_busy)
  );
  pool_first_free #(.N(NRED), .W(RED_W)) u_free_red (
    .free(~red_busy), .pick(rf_pick), .idx(rf_idx), .any(rf_any)
  );
  pool_first_free #(.N(NCHN), .W(CHN_W)) u_free_chn (
    .free(~chn_busy), .pick(cf_pick), .idx(cf_idx), .any(cf_any)
  );

  // ---------------- stage 2: locator result to solver ----------------
  logic [LOC_W-1:0] ptr2_q;
  logic [NLOC-1:0]  elig, gnt2;
  logic [LOC_W-1:0] idx2;
  logic             any2;
  logic [CNT_W-1:0] win_cnt;
  logic             use_red, use_chn;

  always_comb begin
    for (int l = 0; l < NLOC; l++) begin
      elig[l] = loc_hold[l] &&
                ((loc_cnt_q[l] == '0) ||
                 (loc_cnt_q[l] == CNT_W'(1) && (rf_any || cf_any)) ||
                 (loc_cnt_q[l] >  CNT_W'(1) && cf_any));
    end
  end

  pool_rr_pick #(.N(NLOC), .W(LOC_W)) u_pick_loc (
    .req(elig), .ptr(ptr2_q), .gnt(gnt2), .idx(idx2), .any(any2)
  );

  always_comb begin
    win_cnt = '0;
    for (int l = 0; l < NLOC; l++)
      if (gnt2[l]) win_cnt = loc_cnt_q[l];
  end

  assign use_red   = any2 && (win_cnt == CNT_W'(1)) && rf_any;
  assign use_chn   = any2 && ((win_cnt > CNT_W'(1)) || ((win_cnt == CNT_W'(1)) && !rf_any));
  assign red_start = use_red ? rf_pick : '0;
  assign chn_start = use_chn ? cf_pick : '0;
  assign loc_rel   = gnt2;
  assign sol_loc   = idx2;

  always_comb begin
    sol_chan = '0;
    for (int l = 0; l < NLOC; l++)
      if (gnt2[l]) sol_chan = loc_ch_q[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr2_q <= '0;
    else if (any2)  ptr2_q <= (idx2 == LOC_W'(NLOC-1)) ? '0 : idx2 + 1'b1;
  end

  // ---------------- per-locator state ----------------
  for (genvar l = 0; l < NLOC; l++) begin : g_loc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        loc_st_q[l]  <= LOC_IDLE;
        loc_ch_q[l]  <= '0;
        loc_cnt_q[l] <= '0;
      end else begin
        unique case (loc_st_q[l])
          LOC_IDLE: if (loc_start[l]) begin
            loc_st_q[l] <= LOC_RUN;
            loc_ch_q[l] <= idx1;
          end
          LOC_RUN: if (loc_done[l]) begin
            loc_st_q[l]  <= LOC_HOLD;
            loc_cnt_q[l] <= loc_errcnt[l*CNT_W +: CNT_W];
          end
          LOC_HOLD: if (loc_rel[l]) loc_st_q[l] <= LOC_IDLE;
          default: loc_st_q[l] <= LOC_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pool_dispatch_chk.sv
module pool_dispatch_chk #(
  parameter int NCH   = 8,
  parameter int NLOC  = 3,
  parameter int NRED  = 2,
  parameter int NCHN  = 1,
  parameter int CNT_W = 4,
  parameter int CH_W  = 3,
  parameter int LOC_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        blk_valid,
  input logic [NCH-1:0]        blk_nz,
  input logic [NCH-1:0]        blk_ready,
  input logic [NLOC-1:0]       loc_start,
  input logic [NRED-1:0]       red_start,
  input logic [NRED-1:0]       red_done,
  input logic [NCHN-1:0]       chn_start,
  input logic [NCHN-1:0]       chn_done
);
  logic [NRED-1:0] red_seen;
  logic [NCHN-1:0] chn_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red_seen <= '0;
      chn_seen <= '0;
    end else begin
      red_seen <= (red_seen & ~red_done) | red_start;
      chn_seen <= (chn_seen & ~chn_done) | chn_start;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_ZERO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid[c] && !blk_nz[c]) |-> blk_ready[c]); // R1
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready & ~blk_valid) == '0); // R5
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(blk_ready & blk_valid & blk_nz) <= 1); // R3
  AST_LOC_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loc_start)); // R2

  for (genvar l = 0; l < NLOC; l++) begin : g_loc
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      loc_start[l] |=> !loc_start[l]); // R4
  end

  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({red_start, chn_start}) <= 1); // R11
  AST_RED_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (red_start & red_seen) == '0); // R10
  AST_CHN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (chn_start & chn_seen) == '0); // R10
endmodule

bind pool_dispatch pool_dispatch_chk #(
  .NCH(NCH), .NLOC(NLOC), .NRED(NRED), .NCHN(NCHN), .CNT_W(CNT_W),
  .CH_W(CH_W), .LOC_W(LOC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_nz(blk_nz),
  .blk_ready(blk_ready), .loc_start(loc_start), .red_start(red_start),
  .red_done(red_done), .chn_start(chn_start), .chn_done(chn_done)
);

// File: tb/pool_dispatch_bench.sv
`timescale 1ns/1ps
module pool_dispatch_bench;
  localparam int NCH = 8, NLOC = 2, NRED = 1, NCHN = 1, CNT_W = 4;
  localparam int CW = 3, LW = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]        blk_valid, blk_nz, blk_ready;
  logic [NCH*LW-1:0]     blk_unit;
  logic [NLOC-1:0]       loc_start, loc_done;
  logic [CW-1:0]         loc_chan, sol_chan;
  logic [NLOC*CNT_W-1:0] loc_errcnt;
  logic [NRED-1:0]       red_start, red_done;
  logic [NCHN-1:0]       chn_start, chn_done;
  logic [LW-1:0]         sol_loc;

  int checks = 0;
  int errors = 0;

  // bench reference state
  logic [7:0] pend, nzm, exp_ready;
  int st [NLOC];
  int ptr1, winner, freel;

  always #2.5 clk = ~clk;

  pool_dispatch #(.NCH(NCH), .NLOC(NLOC), .NRED(NRED), .NCHN(NCHN), .CNT_W(CNT_W)) u_pool_dispatch (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_nz(blk_nz),
    .blk_ready(blk_ready), .blk_unit(blk_unit), .loc_start(loc_start),
    .loc_chan(loc_chan), .loc_done(loc_done), .loc_errcnt(loc_errcnt),
    .red_start(red_start), .red_done(red_done), .chn_start(chn_start),
    .chn_done(chn_done), .sol_chan(sol_chan), .sol_loc(sol_loc)
  );

  task automatic check_eq(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clear_in();
    blk_valid = '0; blk_nz = '0; loc_done = '0; loc_errcnt = '0;
    red_done = '0; chn_done = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ptr1 = 0;
    for (int l = 0; l < NLOC; l++) st[l] = 0;
  endtask

  // one cycle of the exhaustive sweep; locators answer with count 0 at once
  task automatic sweep_cycle();
    @(negedge clk);
    blk_valid = pend;
    blk_nz    = nzm & pend;
    loc_errcnt = '0;
    for (int l = 0; l < NLOC; l++) loc_done[l] = (st[l] == 1);
    #1;
    exp_ready = pend & ~nzm;
    winner = -1;
    freel  = -1;
    for (int l = NLOC-1; l >= 0; l--) if (st[l] == 0) freel = l;
    if (freel >= 0)
      for (int k = NCH-1; k >= 0; k--)
        if (pend[(ptr1+k)%NCH] && nzm[(ptr1+k)%NCH]) winner = (ptr1+k)%NCH;
    if (winner >= 0) exp_ready[winner] = 1'b1;
    check_eq("R1/R3 ready", int'(blk_ready), int'(exp_ready));
    check_eq("R2 loc_start", int'(loc_start), (winner >= 0) ? (1 << freel) : 0);
    if (winner >= 0) begin
      check_eq("R2 loc_chan", int'(loc_chan), winner);
      check_eq("R2 blk_unit", int'(blk_unit[winner*LW +: LW]), freel);
    end
    check_eq("R9 no solver", int'({red_start, chn_start}), 0);
    pend = pend & ~exp_ready;
    for (int l = 0; l < NLOC; l++) begin
      if (st[l] == 1) st[l] = 2;
      else if (st[l] == 2) st[l] = 0;
    end
    if (winner >= 0) begin
      st[freel] = 1;
      ptr1 = (winner + 1) % NCH;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R12: reset state
    #1;
    check_eq("R12 ready", int'(blk_ready), 0);
    check_eq("R12 starts", int'({loc_start, red_start, chn_start}), 0);

    // R1 R2 R3: every request mask under two syndrome patterns
    for (int pat = 0; pat < 2; pat++) begin
      for (int v = 1; v < 256; v++) begin
        pend = 8'(v);
        nzm  = (pat == 0) ? 8'hFF : 8'h5A;
        while (pend != 8'h00) sweep_cycle();
        repeat (3) sweep_cycle();
      end
    end

    // directed scenario
    do_reset();
    cyc(); blk_valid = 8'h03; blk_nz = 8'h03; #1;
    check_eq("R3 low wins", int'(blk_ready), 8'h01);
    check_eq("R2 loc0", int'(loc_start), 1);
    cyc(); blk_valid = 8'h02; blk_nz = 8'h02; #1;
    check_eq("R2 loc1", int'(loc_start), 2);
    check_eq("R2 chan1", int'(loc_chan), 1);
    cyc(); blk_valid = 8'h0C; blk_nz = 8'h04; loc_done = 2'b01; loc_errcnt = 8'h01; #1;
    check_eq("R5 stall R1 retire", int'(blk_ready), 8'h08);
    check_eq("R5 no start", int'(loc_start), 0);
    cyc(); blk_valid = 8'h04; blk_nz = 8'h04; #1;
    check_eq("R6 red_start", int'(red_start), 1);
    check_eq("R6 chn idle", int'(chn_start), 0);
    check_eq("R6 sol_chan", int'(sol_chan), 0);
    check_eq("R6 sol_loc", int'(sol_loc), 0);
    check_eq("R4 not yet free", int'(blk_ready), 0);
    cyc(); blk_valid = 8'h04; blk_nz = 8'h04; loc_done = 2'b10; loc_errcnt = 8'h10; #1;
    check_eq("R4 regrant", int'(blk_ready), 8'h04);
    check_eq("R4 loc0 again", int'(loc_start), 1);
    cyc(); loc_done = 2'b01; loc_errcnt = 8'h03; #1;
    check_eq("R7 fallback", int'(chn_start), 1);
    check_eq("R7 red none", int'(red_start), 0);
    check_eq("R7 sol_chan", int'(sol_chan), 1);
    check_eq("R7 sol_loc", int'(sol_loc), 1);
    cyc(); red_done = 1'b1; #1;
    check_eq("R8 wait busy", int'({red_start, chn_start}), 0);
    cyc(); chn_done = 1'b1; #1;
    check_eq("R8 no red", int'({red_start, chn_start}), 0);
    cyc(); #1;
    check_eq("R8 chn_start", int'(chn_start), 1);
    check_eq("R8 sol_chan", int'(sol_chan), 2);
    cyc(); loc_done = 2'b10; loc_errcnt = 8'h10; #1;
    check_eq("R10 idle done", int'({red_start, chn_start}), 0);
    cyc(); #1;
    check_eq("R10 ignored", int'({red_start, chn_start}), 0);
    cyc(); blk_valid = 8'h80; blk_nz = 8'h80; #1;
    check_eq("R9 grant", int'(loc_start), 1);
    check_eq("R9 chan7", int'(loc_chan), 7);
    cyc(); loc_done = 2'b01; loc_errcnt = 8'h00; #1;
    cyc(); #1;
    check_eq("R9 no solver", int'({red_start, chn_start}), 0);
    cyc(); blk_valid = 8'h10; blk_nz = 8'h10; #1;
    check_eq("R9 released", int'(loc_start), 1);

    // R11: two results at once share one full unit
    do_reset();
    cyc(); blk_valid = 8'h60; blk_nz = 8'h60; #1;
    check_eq("R3 ch5", int'(blk_ready), 8'h20);
    cyc(); blk_valid = 8'h40; blk_nz = 8'h40; #1;
    check_eq("R3 ch6", int'(blk_ready), 8'h40);
    cyc(); loc_done = 2'b11; loc_errcnt = 8'h22; #1;
    cyc(); #1;
    check_eq("R11 first", int'(chn_start), 1);
    check_eq("R11 first chan", int'(sol_chan), 5);
    cyc(); chn_done = 1'b1; #1;
    check_eq("R11 one at a time", int'({red_start, chn_start}), 0);
    cyc(); #1;
    check_eq("R11 second", int'(chn_start), 1);
    check_eq("R11 second chan", int'(sol_chan), 6);
    check_eq("R11 second loc", int'(sol_loc), 1);
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule